// File: doc/BRIEF.md
# Camera RGB Colour Correction Pipeline

This block takes one pixel at a time as three 10-bit colour samples, red, green and blue, from an upstream colour-separation stage. It runs each pixel through a fixed chain of corrections and returns gamma-corrected red, green and blue. The stages, in order, are:

1. A programmable 3x3 colour matrix that adapts the sensor's filter response.
2. White-balance gain on the red and blue channels.
3. A signed black offset.
4. A knee compressor for highlights.
5. A 16-segment piecewise-linear gamma curve.

A white-clip flag enters with each pixel and leaves with the same pixel, so that later chroma stages can use it.

Pixels move on valid/ready handshakes at both ends. A pixel is taken in on a rising clock edge where `in_valid` and `in_ready` are both high. A pixel leaves on an edge where `out_valid` and `out_ready` are both high. The pipeline advances as one unit, and only while its output register is empty or being drained. When `out_valid` is high and `out_ready` is low, the following hold until the consumer takes the pixel:

- the whole pipe stalls;
- `in_ready` is low;
- the output pixel is held unchanged.

All parameters are written through a plain register port into a shadow bank. The shadow bank is copied to the working set only on a `frame_start` pulse, so a frame is never processed with a mix of old and new settings.

Top module: `rgb_color_pipe`

## Requirements
- R1: A pixel accepted at a clock edge appears on the output 5 edges later when the output is not stalled. While `out_valid` is high and `out_ready` is low, `in_ready` is low and the output pixel and flag stay unchanged on the next cycle. Pixels leave in the order they entered.
- R2: The matrix computes, for each output row o, (c[o][R]·R + c[o][G]·G + c[o][B]·B + 128) >> 8, with an arithmetic shift. Coefficient c[o][i] sits at address 3·o + i, with o and i taken as 0=red, 1=green, 2=blue. Coefficients are 10-bit two's complement with 8 fraction bits, taken from `cfg_wdata[9:0]`.
- R3: Red is multiplied by the gain at address 9 and blue by the gain at address 10, each as (x·gain + 128) >> 8. Gains are unsigned 10-bit with 8 fraction bits. Green passes the gain stage unchanged.
- R4: The black offset at address 11 is an 11-bit two's-complement value from `cfg_wdata[10:0]`. It is added to all three channels after the gain stage.
- R5: The knee point (address 12, 10 bits) and the knee slope (address 13, with 8 fraction bits) set the knee. An input at or below the knee point passes unchanged. An input above it becomes kp + (((x − kp)·slope) >> 8). The knee is the same for all three channels.
- R6: Gamma breakpoint k (0 to 16) is a 10-bit value at address 16 + k. For an input x, the segment is s = x[9:6] and the fraction is f = x[5:0]. The output is bp[s] + (((bp[s+1] − bp[s])·f) >>> 6).
- R7: Each stage clamps its result to the range 0 to 1023 before the next stage uses it.
- R8: The white-clip flag taken in with a pixel leaves with that same pixel.
- R9: Register writes change nothing in processing until a `frame_start` pulse. Writes to addresses outside 0–13 and 16–32 have no effect.
- R10: After reset, `out_valid` is low and `in_ready` is high. The working set is:
  - identity matrix, with 256 on the diagonal and 0 elsewhere;
  - both gains 256;
  - black offset 0;
  - knee point 1023 and slope 256;
  - gamma breakpoints min(64·k, 1023).
- R11: A knee-slope write above 256 is stored as 256, so the knee slope never exceeds unity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Pipeline can take a pixel |
| in_r | input | 10 | Red sample in |
| in_g | input | 10 | Green sample in |
| in_b | input | 10 | Blue sample in |
| in_wclip | input | 1 | White-clip flag in |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Consumer takes the output pixel |
| out_r | output | 10 | Corrected red |
| out_g | output | 10 | Corrected green |
| out_b | output | 10 | Corrected blue |
| out_wclip | output | 1 | White-clip flag out, aligned with the pixel |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register address |
| cfg_wdata | input | 16 | Register write data |
| frame_start | input | 1 | Copy the shadow settings to the working set |

## Verification
The assertions check the following on every cycle:

- that a stalled output pixel holds and that input is refused while the output is stalled;
- that the working settings change only in the cycle after a frame-start pulse;
- that the working knee slope never exceeds unity.

The bench's scenarios show the rest, by comparing each output pixel against an arithmetic model of the requirements. This covers the matrix with negative coefficients, clamping at both rails, the red/blue-only gains, the offset, the knee and a concave gamma curve. It also covers the deferred and ignored register writes and ordering under random back-pressure.

// File: rtl/rgbp_pkg.sv
package rgbp_pkg;
  parameter int PIX_W     = 10;
  parameter int COEF_W    = 10;
  parameter int FRAC_W    = 8;
  parameter int GSEG_LOG2 = 4;
  parameter int ADDR_W    = 6;
  parameter int DATA_W    = 16;

  localparam int GSEG      = 1 << GSEG_LOG2;
  localparam int GBP_N     = GSEG + 1;
  localparam int GFR_W     = PIX_W - GSEG_LOG2;
  localparam int SLOPE_W   = FRAC_W + 1;
  localparam int BLK_W     = PIX_W + 1;
  localparam int PIX_MAX   = (1 << PIX_W) - 1;
  localparam int UNITY     = 1 << FRAC_W;
  localparam int NCOEF     = 9;
  localparam int A_GAIN_R  = NCOEF;
  localparam int A_GAIN_B  = NCOEF + 1;
  localparam int A_BLACK   = NCOEF + 2;
  localparam int A_KNEE_PT = NCOEF + 3;
  localparam int A_KNEE_SL = NCOEF + 4;
  localparam int A_GAMMA0  = 16;

  typedef logic [PIX_W-1:0] pix_t;

  typedef struct packed {
    logic [NCOEF-1:0][COEF_W-1:0] coef;
    logic [COEF_W-1:0]            gain_r;
    logic [COEF_W-1:0]            gain_b;
    logic [BLK_W-1:0]             black;
    logic [PIX_W-1:0]             knee_pt;
    logic [SLOPE_W-1:0]           knee_sl;
    logic [GBP_N-1:0][PIX_W-1:0]  gbp;
  } cfg_t;

  // Clamp a signed intermediate to the pixel range.
  function automatic pix_t sat_pix(input int v);
    if (v < 0) return '0;
    if (v > PIX_MAX) return pix_t'(PIX_MAX);
    return pix_t'(v);
  endfunction

  function automatic cfg_t cfg_reset();
    cfg_t c;
    c = '0;
    for (int k = 0; k < NCOEF; k++)
      c.coef[k] = (k % 4 == 0) ? COEF_W'(UNITY) : '0;
    c.gain_r  = COEF_W'(UNITY);
    c.gain_b  = COEF_W'(UNITY);
    c.black   = '0;
    c.knee_pt = pix_t'(PIX_MAX);
    c.knee_sl = SLOPE_W'(UNITY);
    for (int k = 0; k < GBP_N; k++)
      c.gbp[k] = pix_t'((k * (PIX_MAX + 1) / GSEG > PIX_MAX) ? PIX_MAX
                                                            : k * (PIX_MAX + 1) / GSEG);
    return c;
  endfunction
endpackage

// File: rtl/rgbp_cfg_bank.sv
module rgbp_cfg_bank
  import rgbp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              commit,
  output cfg_t              active
);
  cfg_t shadow, shadow_nxt;
  int   a;

  always_comb begin
    shadow_nxt = shadow;
    a          = int'(wr_addr);
    if (wr_en) begin
      for (int k = 0; k < NCOEF; k++)
        if (a == k) shadow_nxt.coef[k] = wr_data[COEF_W-1:0];
      if (a == A_GAIN_R)  shadow_nxt.gain_r  = wr_data[COEF_W-1:0];
      if (a == A_GAIN_B)  shadow_nxt.gain_b  = wr_data[COEF_W-1:0];
      if (a == A_BLACK)   shadow_nxt.black   = wr_data[BLK_W-1:0];
      if (a == A_KNEE_PT) shadow_nxt.knee_pt = wr_data[PIX_W-1:0];
      if (a == A_KNEE_SL)
        shadow_nxt.knee_sl = (wr_data > DATA_W'(UNITY)) ? SLOPE_W'(UNITY)
                                                        : wr_data[SLOPE_W-1:0];
      for (int k = 0; k < GBP_N; k++)
        if (a == A_GAMMA0 + k) shadow_nxt.gbp[k] = wr_data[PIX_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= cfg_reset();
      active <= cfg_reset();
    end else begin
      shadow <= shadow_nxt;
      if (commit) active <= shadow;
    end
  end
endmodule

// File: rtl/rgbp_matrix.sv
module rgbp_matrix
  import rgbp_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         en,
  input  pix_t [2:0]                   px_in,
  input  logic [NCOEF-1:0][COEF_W-1:0] coef,
  output pix_t [2:0]                   px_out
);
  int acc [3];

  always_comb begin
    for (int row = 0; row < 3; row++) begin
      acc[row] = 1 << (FRAC_W - 1);
      for (int col = 0; col < 3; col++)
        acc[row] += int'($signed(coef[row*3+col])) * int'({1'b0, px_in[col]});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) px_out <= '0;
    else if (en)
      for (int row = 0; row < 3; row++)
        px_out[row] <= sat_pix(acc[row] >>> FRAC_W);
  end
endmodule

// File: rtl/rgbp_tone.sv
module rgbp_tone
  import rgbp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  pix_t               px_in,
  input  logic [COEF_W-1:0]  gain,
  input  logic [BLK_W-1:0]   black,
  input  pix_t               knee_pt,
  input  logic [SLOPE_W-1:0] knee_sl,
  output pix_t               px_out
);
  pix_t g_q, b_q;
  int   g_v, b_v, k_v;

  always_comb begin
    g_v = (int'(px_in) * int'(gain) + (1 << (FRAC_W - 1))) >>> FRAC_W;
    b_v = int'(g_q) + int'($signed(black));
    if (b_q <= knee_pt) k_v = int'(b_q);
    else k_v = int'(knee_pt) + (((int'(b_q) - int'(knee_pt)) * int'(knee_sl)) >>> FRAC_W);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g_q    <= '0;
      b_q    <= '0;
      px_out <= '0;
    end else if (en) begin
      g_q    <= sat_pix(g_v);
      b_q    <= sat_pix(b_v);
      px_out <= sat_pix(k_v);
    end
  end
endmodule

// File: rtl/rgbp_gamma.sv
module rgbp_gamma
  import rgbp_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en,
  input  pix_t                        px_in,
  input  logic [GBP_N-1:0][PIX_W-1:0] bp,
  output pix_t                        px_out
);
  logic [GSEG_LOG2-1:0] seg;
  logic [GFR_W-1:0]     fr;
  int                   lo, hi, v;

  always_comb begin
    seg = px_in[PIX_W-1 -: GSEG_LOG2];
    fr  = px_in[GFR_W-1:0];
    lo  = 0;
    hi  = 0;
    for (int k = 0; k < GSEG; k++)
      if (int'(seg) == k) begin
        lo = int'(bp[k]);
        hi = int'(bp[k+1]);
      end
    v = lo + (((hi - lo) * int'(fr)) >>> GFR_W);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) px_out <= '0;
    else if (en) px_out <= sat_pix(v);
  end
endmodule

// File: rtl/rgb_color_pipe.sv
module rgb_color_pipe
  import rgbp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PIX_W-1:0]  in_r,
  input  logic [PIX_W-1:0]  in_g,
  input  logic [PIX_W-1:0]  in_b,
  input  logic              in_wclip,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PIX_W-1:0]  out_r,
  output logic [PIX_W-1:0]  out_g,
  output logic [PIX_W-1:0]  out_b,
  output logic              out_wclip,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              frame_start
);
  localparam int DEPTH = 5;  // matrix 1 + gain/offset/knee 3 + gamma 1

  cfg_t             act_cfg;
  logic             adv;
  logic [DEPTH-1:0] vld, wc;
  pix_t [2:0]       mx;
  pix_t             tn [3];
  pix_t             gm [3];

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  rgbp_cfg_bank u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_addr (cfg_addr),
    .wr_data (cfg_wdata),
    .commit  (frame_start),
    .active  (act_cfg)
  );

  rgbp_matrix u_mtx (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (adv),
    .px_in  ({in_b, in_g, in_r}),
    .coef   (act_cfg.coef),
    .px_out (mx)
  );

  for (genvar ch = 0; ch < 3; ch++) begin : g_ch
    logic [COEF_W-1:0] gain_sel;
    if (ch == 0) begin : g_red
      assign gain_sel = act_cfg.gain_r;
    end else if (ch == 2) begin : g_blue
      assign gain_sel = act_cfg.gain_b;
    end else begin : g_green
      assign gain_sel = COEF_W'(UNITY);
    end

    rgbp_tone u_tone (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (adv),
      .px_in   (mx[ch]),
      .gain    (gain_sel),
      .black   (act_cfg.black),
      .knee_pt (act_cfg.knee_pt),
      .knee_sl (act_cfg.knee_sl),
      .px_out  (tn[ch])
    );

    rgbp_gamma u_gam (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (adv),
      .px_in  (tn[ch]),
      .bp     (act_cfg.gbp),
      .px_out (gm[ch])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      wc  <= '0;
    end else if (adv) begin
      vld <= {vld[DEPTH-2:0], in_valid};
      wc  <= {wc[DEPTH-2:0], in_wclip};
    end
  end

  assign out_valid = vld[DEPTH-1];
  assign out_wclip = wc[DEPTH-1];
  assign out_r     = gm[0];
  assign out_g     = gm[1];
  assign out_b     = gm[2];
endmodule

// File: rtl/rgbp_checks.sv
module rgbp_checks
  import rgbp_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PIX_W-1:0] out_r,
  input logic [PIX_W-1:0] out_g,
  input logic [PIX_W-1:0] out_b,
  input logic             out_wclip,
  input logic             frame_start,
  input cfg_t             act_cfg
);
  // R1: a stalled output pixel is held
  p_stall_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable({out_r, out_g, out_b, out_wclip}));

  // R1: no intake while the output is stalled
  p_no_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R9: the working set changes only after a frame-start pulse
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(act_cfg));

  // R11: the working knee slope never exceeds unity
  p_slope_cap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    int'(act_cfg.knee_sl) <= UNITY);
endmodule

bind rgb_color_pipe rgbp_checks u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_r       (out_r),
  .out_g       (out_g),
  .out_b       (out_b),
  .out_wclip   (out_wclip),
  .frame_start (frame_start),
  .act_cfg     (act_cfg)
);

// File: tb/test_rgb_color_pipe.sv
module test_rgb_color_pipe;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_wclip = 1'b0, out_ready = 1'b1;
  logic [9:0] in_r = '0, in_g = '0, in_b = '0;
  logic in_ready, out_valid, out_wclip;
  logic [9:0] out_r, out_g, out_b;
  logic cfg_we = 1'b0, frame_start = 1'b0;
  logic [5:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;

  int checks = 0, failures = 0;
  bit stall_mode = 0;
  logic [30:0] exp_q[$];
  string tag_q[$];

  // pending (shadow) and applied model settings
  int p_c[9], m_c[9], p_bp[17], m_bp[17];
  int p_gr, p_gb, p_blk, p_kp, p_ks, m_gr, m_gb, m_blk, m_kp, m_ks;

  always #(CLK_PERIOD/2) clk = ~clk;

  rgb_color_pipe i_rgb_color_pipe (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_r(in_r), .in_g(in_g), .in_b(in_b), .in_wclip(in_wclip),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_r(out_r), .out_g(out_g), .out_b(out_b), .out_wclip(out_wclip),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .frame_start(frame_start)
  );

  always @(negedge clk) out_ready <= stall_mode ? ($urandom_range(2) != 0) : 1'b1;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int sat(int v);
    return v < 0 ? 0 : (v > 1023 ? 1023 : v);
  endfunction

  function automatic logic [30:0] model(int r, int g, int b, bit w);
    int x[3], y[3];
    x[0] = r; x[1] = g; x[2] = b;
    for (int o = 0; o < 3; o++)
      y[o] = sat((m_c[3*o]*x[0] + m_c[3*o+1]*x[1] + m_c[3*o+2]*x[2] + 128) >>> 8);
    y[0] = sat((y[0]*m_gr + 128) >>> 8);
    y[2] = sat((y[2]*m_gb + 128) >>> 8);
    for (int o = 0; o < 3; o++) begin
      int v, s, f;
      v = sat(y[o] + m_blk);
      if (v > m_kp) v = sat(m_kp + (((v - m_kp) * m_ks) >>> 8));
      s = v >> 6; f = v & 63;
      y[o] = sat(m_bp[s] + (((m_bp[s+1] - m_bp[s]) * f) >>> 6));
    end
    return {y[0][9:0], y[1][9:0], y[2][9:0], w};
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 9; k++) p_c[k] = (k % 4 == 0) ? 256 : 0;
    for (int k = 0; k < 17; k++) p_bp[k] = (64*k > 1023) ? 1023 : 64*k;
    p_gr = 256; p_gb = 256; p_blk = 0; p_kp = 1023; p_ks = 256;
    m_c = p_c; m_bp = p_bp;
    m_gr = p_gr; m_gb = p_gb; m_blk = p_blk; m_kp = p_kp; m_ks = p_ks;
  endtask

  task automatic cfg_write(int a, int d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a[5:0]; cfg_wdata = d[15:0];
    @(negedge clk);
    cfg_we = 0;
    if (a < 9) p_c[a] = ((d & 1023) >= 512) ? (d & 1023) - 1024 : (d & 1023);
    else if (a == 9) p_gr = d & 1023;
    else if (a == 10) p_gb = d & 1023;
    else if (a == 11) p_blk = ((d & 2047) >= 1024) ? (d & 2047) - 2048 : (d & 2047);
    else if (a == 12) p_kp = d & 1023;
    else if (a == 13) p_ks = (d > 256) ? 256 : d;
    else if (a >= 16 && a <= 32) p_bp[a-16] = d & 1023;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic apply();
    drain();
    @(negedge clk); frame_start = 1;
    @(negedge clk); frame_start = 0;
    m_c = p_c; m_bp = p_bp;
    m_gr = p_gr; m_gb = p_gb; m_blk = p_blk; m_kp = p_kp; m_ks = p_ks;
  endtask

  task automatic send(int r, int g, int b, bit w, string t);
    @(negedge clk);
    in_valid = 1; in_r = r[9:0]; in_g = g[9:0]; in_b = b[9:0]; in_wclip = w;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    exp_q.push_back(model(r, g, b, w));
    tag_q.push_back(t);
    @(posedge clk);
    #1 in_valid = 0;
  endtask

  task automatic set_matrix(int c0, int c1, int c2, int c3, int c4, int c5, int c6, int c7, int c8);
    cfg_write(0, c0); cfg_write(1, c1); cfg_write(2, c2);
    cfg_write(3, c3); cfg_write(4, c4); cfg_write(5, c5);
    cfg_write(6, c6); cfg_write(7, c7); cfg_write(8, c8);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_n && out_valid && out_ready) begin
        if (exp_q.size() == 0) check("R1 unexpected output", 1, 0);
        else begin
          logic [30:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({t, " pixel"}, int'({out_r, out_g, out_b}), int'(e[30:1]));
          check({t, " R8 wclip"}, int'(out_wclip), int'(e[0]));
        end
      end
      if (rst_n && out_valid && !out_ready) check("R1 in_ready while stalled", int'(in_ready), 0);
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    check("R10 out_valid after reset", int'(out_valid), 0);
    check("R10 in_ready after reset", int'(in_ready), 1);

    // defaults: identity, linear gamma
    send(500, 100, 37, 1, "R10");
    send(1023, 0, 960, 0, "R10 R6");
    drain();

    // latency
    begin
      int k;
      send(321, 654, 87, 1, "R1");
      k = 0;
      do begin @(negedge clk); #1; k++; end while (!out_valid && k < 20);
      check("R1 latency", k, 5);
    end
    drain();

    // matrix with negative coefficients and clamping
    set_matrix(384, 960, 960, 0, 256, 0, 896, 64, 384);
    apply();
    send(1023, 0, 0, 0, "R2 R7 high clamp");
    send(0, 1023, 1023, 1, "R2 R7 low clamp");
    send(200, 300, 400, 0, "R2");
    send(640, 20, 900, 1, "R2");
    set_matrix(256, 0, 0, 0, 256, 0, 0, 0, 256);

    // white balance on red and blue only
    cfg_write(9, 512); cfg_write(10, 128);
    apply();
    send(300, 300, 300, 0, "R3");
    send(700, 700, 700, 1, "R3 R7");

    // black offset
    cfg_write(9, 256); cfg_write(10, 256); cfg_write(11, 2048 - 40);
    apply();
    send(20, 500, 1000, 0, "R4 negative");
    cfg_write(11, 100);
    apply();
    send(1000, 10, 923, 1, "R4 positive");
    cfg_write(11, 0);

    // knee: slope clamp then half slope
    cfg_write(12, 600); cfg_write(13, 400);
    apply();
    send(900, 700, 100, 0, "R11");
    cfg_write(13, 128);
    apply();
    send(900, 600, 100, 1, "R5");
    send(1023, 601, 599, 0, "R5");
    cfg_write(12, 1023); cfg_write(13, 256);

    // concave gamma curve
    for (int k = 0; k <= 16; k++)
      cfg_write(16 + k, $rtoi(1023.0 * ((real'(k) / 16.0) ** 0.35) + 0.5));
    apply();
    send(0, 64, 1023, 0, "R6");
    send(37, 500, 959, 1, "R6");
    send(5, 128, 700, 0, "R6");

    // deferred and ignored writes
    cfg_write(9, 512);
    send(100, 100, 100, 0, "R9 pending write");
    cfg_write(14, 999); cfg_write(40, 7);
    apply();
    send(100, 100, 100, 1, "R9 after frame start");
    send(400, 250, 800, 0, "R9 unmapped ignored");

    // random stream under back-pressure
    stall_mode = 1;
    for (int i = 0; i < 60; i++)
      send($urandom_range(1023), $urandom_range(1023), $urandom_range(1023),
           1'($urandom_range(1)), "R1 R8 stream");
    drain();
    stall_mode = 0;
    drain();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule